// File: doc/BRIEF.md
# Endpoint Descriptor List Walker

This block traverses a chain of endpoint descriptors kept in shared memory and, for each one, decides whether a transfer descriptor is waiting to be serviced. A start pulse launches a walk from the address held in the list head input. Each descriptor is four 32-bit words on a 16-byte boundary. The walker reads them one at a time through a word-read port with a valid/ready handshake, then judges the descriptor.

When a descriptor has work pending, the walker raises a service request toward a downstream transaction engine. The request carries the descriptor address, the aligned transfer descriptor address, the decoded control fields and the toggle-carry flag. The walker holds the request until it is acknowledged. Descriptors that are skipped, isochronous, halted or empty are passed over without a request. A next-descriptor pointer with zero address bits ends the walk with a one-cycle done pulse. Flag bits packed into the low nibble of the pointer words are always stripped before those words are used as addresses.

Top module: `ed_walker`

## Requirements
- R1: After reset, `rd_valid`, `svc_valid` and `list_done` are low and `cur_ed` and all service payload outputs are zero.
- R2: Once a walk reaches a descriptor at address A, `cur_ed` shows A from the next cycle. The four words are read at A+0x0 (control), A+0x4 (tail), A+0x8 (head) and A+0xC (next), in that order, one word per accepted handshake. `rd_addr` holds steady while `rd_valid` is high and `rd_ready` is low.
- R3: A descriptor whose control bit 14 is set produces no service request.
- R4: A descriptor whose control bit 15 (isochronous) is set produces no service request.
- R5: A descriptor whose head word has bit 0 (halted) set produces no service request.
- R6: A descriptor produces no service request when bits 31:4 of its head word equal bits 31:4 of its tail word. Bits 3:0 of both words play no part in this comparison.
- R7: Any other descriptor raises `svc_valid` two cycles after the handshake that returned its fourth word. The payload is held stable until acknowledged and carries the following:
  - the descriptor address;
  - the transfer descriptor address, which is the head word with bits 3:0 cleared;
  - the function address (control 6:0), endpoint (10:7), direction (12:11), low speed (13) and maximum packet size (26:16);
  - the toggle carry, taken from head bit 1.

  Control bits 31:27 are ignored.
- R8: In the cycle after `svc_valid` and `svc_ack` are both high, `svc_valid` is low and the walk moves on. No reads are issued while a request waits. `svc_ack` has no effect while `svc_valid` is low.
- R9: The next pointer with bits 3:0 cleared gives the following descriptor address. If that address is zero, `list_done` pulses for one cycle and `cur_ed` reads zero in the same cycle. The pulse comes two cycles after the last read handshake for a passed-over descriptor, and one cycle after the acknowledge for a serviced one. For a passed-over descriptor with a non-zero next address, the first read of the next descriptor is likewise due two cycles after the last read handshake.
- R10: A start while idle with `list_head` bits 31:4 all zero produces `list_done` in the next cycle, with no memory read.
- R11: A start pulse that arrives while a walk is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| list_head | input | 32 | Address of the first descriptor; bits 3:0 ignored |
| start | input | 1 | Begin a walk (taken only when idle) |
| rd_valid | output | 1 | Word read request valid |
| rd_addr | output | 32 | Byte address of the requested word |
| rd_ready | input | 1 | Memory accepts the request; `rd_data` valid in the same cycle |
| rd_data | input | 32 | Read data |
| cur_ed | output | 32 | Address of the descriptor being handled, zero when the walk ends |
| svc_valid | output | 1 | Service request pending |
| svc_ack | input | 1 | Service request accepted |
| svc_ed_addr | output | 32 | Descriptor address of the request |
| svc_td_addr | output | 32 | Aligned transfer descriptor address |
| svc_func_addr | output | 7 | Device function address |
| svc_ep_num | output | 4 | Endpoint number |
| svc_dir | output | 2 | Direction code |
| svc_low_speed | output | 1 | Low-speed endpoint |
| svc_max_pkt | output | 11 | Maximum packet size |
| svc_toggle | output | 1 | Toggle carry from the head word |
| list_done | output | 1 | One-cycle end-of-list pulse |

## Verification
Every result of this block is due at a fixed distance from a stimulus edge:
- `cur_ed` and the first read follow a start by one cycle.
- A service request, or the next descriptor's first read, or the done pulse, follows the fourth read handshake by two cycles.
- The next read or the done pulse follows an acknowledge by one cycle.
- An empty head produces done one cycle after the start.

The bench runs a behavioural model that advances at each rising edge on the same sampled inputs. It compares every output at the falling edge of every cycle, so each of these latencies is checked at exactly its due cycle. The runs use stalling and always-ready memory, delayed and immediate acknowledges, and stray acknowledges.

// File: rtl/ed_walk_pkg.sv
package ed_walk_pkg;
  localparam int WORD_W   = 32;
  localparam int ED_WORDS = 4;
  localparam int ALIGN_W  = 4;

  // control word field positions
  localparam int FA_LSB   = 0;
  localparam int FA_W     = 7;
  localparam int EP_LSB   = 7;
  localparam int EP_W     = 4;
  localparam int DIR_LSB  = 11;
  localparam int DIR_W    = 2;
  localparam int LS_BIT   = 13;
  localparam int SKIP_BIT = 14;
  localparam int ISO_BIT  = 15;
  localparam int MPS_LSB  = 16;
  localparam int MPS_W    = 11;

  // head pointer flag positions
  localparam int HALT_BIT = 0;
  localparam int TOG_BIT  = 1;

  // word order inside a descriptor
  localparam int W_CTRL = 0;
  localparam int W_TAIL = 1;
  localparam int W_HEAD = 2;
  localparam int W_NEXT = 3;

  typedef struct packed {
    logic [FA_W-1:0]  func;
    logic [EP_W-1:0]  ep;
    logic [DIR_W-1:0] dir;
    logic             low_speed;
    logic [MPS_W-1:0] mps;
    logic             toggle;
  } ed_info_t;

  typedef enum logic [1:0] {WS_IDLE, WS_WALK, WS_SERVE} walk_state_t;
endpackage

// File: rtl/edw_fetch.sv
module edw_fetch
  import ed_walk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             go,
  input  logic [AW-1:0]                    go_base,
  output logic                             rd_valid,
  output logic [AW-1:0]                    rd_addr,
  input  logic                             rd_ready,
  input  logic [WORD_W-1:0]                rd_data,
  output logic [ED_WORDS-1:0][WORD_W-1:0]  words,
  output logic                             done
);
  localparam int IDX_W = $clog2(ED_WORDS);
  localparam int BSH   = $clog2(WORD_W / 8);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ED_WORDS - 1);

  logic            busy;
  logic [IDX_W-1:0] idx;
  logic [AW-1:0]   base;
  logic            hs;

  assign hs       = busy & rd_ready;
  assign rd_valid = busy;
  assign rd_addr  = base + (AW'(idx) << BSH);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      idx  <= '0;
      base <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !busy) begin
        busy <= 1'b1;
        idx  <= '0;
        base <= go_base;
      end else if (hs) begin
        if (idx == LAST_IDX) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end

  // one capture register per descriptor word
  for (genvar g = 0; g < ED_WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) words[g] <= '0;
      else if (hs && idx == IDX_W'(g)) words[g] <= rd_data;
    end
  end

  // R2: request address may not move while the memory stalls
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr)));

  // R11: the sequencer never gets a new base while it is reading
  a_r11_go_idle: assert property (@(posedge clk) disable iff (rst)
    go |-> !busy);
endmodule

// File: rtl/edw_qualify.sv
module edw_qualify
  import ed_walk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [WORD_W-1:0] ctrl_w,
  input  logic [WORD_W-1:0] tail_w,
  input  logic [WORD_W-1:0] head_w,
  output logic              service,
  output ed_info_t          info,
  output logic [AW-1:0]     td_addr
);
  logic skip, iso, halted, empty;
  logic unused_bits;

  assign skip   = ctrl_w[SKIP_BIT];
  assign iso    = ctrl_w[ISO_BIT];
  assign halted = head_w[HALT_BIT];
  assign empty  = (head_w[AW-1:ALIGN_W] == tail_w[AW-1:ALIGN_W]);

  assign service = !(skip || iso || halted || empty);

  always_comb begin
    info.func      = ctrl_w[FA_LSB +: FA_W];
    info.ep        = ctrl_w[EP_LSB +: EP_W];
    info.dir       = ctrl_w[DIR_LSB +: DIR_W];
    info.low_speed = ctrl_w[LS_BIT];
    info.mps       = ctrl_w[MPS_LSB +: MPS_W];
    info.toggle    = head_w[TOG_BIT];
  end

  assign td_addr = {head_w[AW-1:ALIGN_W], {ALIGN_W{1'b0}}};

  assign unused_bits = ^{ctrl_w[WORD_W-1:MPS_LSB+MPS_W], tail_w[ALIGN_W-1:0],
                         head_w[ALIGN_W-1:TOG_BIT+1]};
endmodule

// File: rtl/ed_walker.sv
module ed_walker
  import ed_walk_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [AW-1:0]     list_head,
  input  logic              start,
  output logic              rd_valid,
  output logic [AW-1:0]     rd_addr,
  input  logic              rd_ready,
  input  logic [WORD_W-1:0] rd_data,
  output logic [AW-1:0]     cur_ed,
  output logic              svc_valid,
  input  logic              svc_ack,
  output logic [AW-1:0]     svc_ed_addr,
  output logic [AW-1:0]     svc_td_addr,
  output logic [FA_W-1:0]   svc_func_addr,
  output logic [EP_W-1:0]   svc_ep_num,
  output logic [DIR_W-1:0]  svc_dir,
  output logic              svc_low_speed,
  output logic [MPS_W-1:0]  svc_max_pkt,
  output logic              svc_toggle,
  output logic              list_done
);
  walk_state_t state;
  logic [ED_WORDS-1:0][WORD_W-1:0] words;
  logic          fetch_done;
  logic          go;
  logic [AW-1:0] go_base;
  logic          q_service;
  ed_info_t      q_info;
  logic [AW-1:0] q_td;
  logic [AW-1:0] head_al;
  logic [AW-1:0] next_al;
  ed_info_t      svc_info;
  logic          unused_low;

  assign head_al = {list_head[AW-1:ALIGN_W], {ALIGN_W{1'b0}}};
  assign next_al = {words[W_NEXT][AW-1:ALIGN_W], {ALIGN_W{1'b0}}};
  assign unused_low = ^{list_head[ALIGN_W-1:0], words[W_NEXT][ALIGN_W-1:0]};

  edw_fetch #(.AW(AW)) u_fetch (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .go_base  (go_base),
    .rd_valid (rd_valid),
    .rd_addr  (rd_addr),
    .rd_ready (rd_ready),
    .rd_data  (rd_data),
    .words    (words),
    .done     (fetch_done)
  );

  edw_qualify #(.AW(AW)) u_qual (
    .ctrl_w  (words[W_CTRL]),
    .tail_w  (words[W_TAIL]),
    .head_w  (words[W_HEAD]),
    .service (q_service),
    .info    (q_info),
    .td_addr (q_td)
  );

  // launch of the next descriptor fetch
  always_comb begin
    go      = 1'b0;
    go_base = '0;
    case (state)
      WS_IDLE: if (start && head_al != '0) begin
        go = 1'b1; go_base = head_al;
      end
      WS_WALK: if (fetch_done && !q_service && next_al != '0) begin
        go = 1'b1; go_base = next_al;
      end
      WS_SERVE: if (svc_ack && next_al != '0) begin
        go = 1'b1; go_base = next_al;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= WS_IDLE;
      cur_ed      <= '0;
      svc_valid   <= 1'b0;
      svc_ed_addr <= '0;
      svc_td_addr <= '0;
      svc_info    <= '0;
      list_done   <= 1'b0;
    end else begin
      list_done <= 1'b0;
      case (state)
        WS_IDLE: if (start) begin
          if (head_al == '0) begin
            list_done <= 1'b1;
            cur_ed    <= '0;
          end else begin
            cur_ed <= head_al;
            state  <= WS_WALK;
          end
        end
        WS_WALK: if (fetch_done) begin
          if (q_service) begin
            svc_valid   <= 1'b1;
            svc_ed_addr <= cur_ed;
            svc_td_addr <= q_td;
            svc_info    <= q_info;
            state       <= WS_SERVE;
          end else if (next_al == '0) begin
            list_done <= 1'b1;
            cur_ed    <= '0;
            state     <= WS_IDLE;
          end else begin
            cur_ed <= next_al;
          end
        end
        WS_SERVE: if (svc_ack) begin
          svc_valid <= 1'b0;
          if (next_al == '0) begin
            list_done <= 1'b1;
            cur_ed    <= '0;
            state     <= WS_IDLE;
          end else begin
            cur_ed <= next_al;
            state  <= WS_WALK;
          end
        end
        default: state <= WS_IDLE;
      endcase
    end
  end

  assign svc_func_addr = svc_info.func;
  assign svc_ep_num    = svc_info.ep;
  assign svc_dir       = svc_info.dir;
  assign svc_low_speed = svc_info.low_speed;
  assign svc_max_pkt   = svc_info.mps;
  assign svc_toggle    = svc_info.toggle;

  // R7: a pending request keeps its payload until taken
  a_r7_svc_hold: assert property (@(posedge clk) disable iff (rst)
    (svc_valid && !svc_ack) |=> (svc_valid && $stable(svc_td_addr)
      && $stable(svc_ed_addr) && $stable(svc_max_pkt)));

  // R8: no memory traffic while the engine holds a request
  a_r8_quiet_wait: assert property (@(posedge clk) disable iff (rst)
    svc_valid |-> !rd_valid);

  // R8: accepted request drops on the next cycle
  a_r8_drop_after_ack: assert property (@(posedge clk) disable iff (rst)
    (svc_valid && svc_ack) |=> !svc_valid);

  // R9: end of list leaves nothing active and the current pointer cleared
  a_r9_done_clear: assert property (@(posedge clk) disable iff (rst)
    list_done |-> (cur_ed == '0 && !svc_valid && !rd_valid));

  // R10: an empty list head finishes at once without reading
  a_r10_zero_head: assert property (@(posedge clk) disable iff (rst)
    (state == WS_IDLE && start && list_head[AW-1:ALIGN_W] == '0)
      |=> (list_done && !rd_valid));

  // R2: every read falls inside the descriptor named by cur_ed
  a_r2_read_in_ed: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_addr[AW-1:ALIGN_W] == cur_ed[AW-1:ALIGN_W]));
endmodule

// File: tb/sim_ed_walker.sv
`timescale 1ns/1ps
module sim_ed_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] list_head = '0;
  logic        start = 1'b0;
  logic        rd_valid;
  logic [31:0] rd_addr;
  logic        rd_ready = 1'b0;
  logic [31:0] rd_data;
  logic [31:0] cur_ed;
  logic        svc_valid;
  logic        svc_ack = 1'b0;
  logic [31:0] svc_ed_addr, svc_td_addr;
  logic [6:0]  svc_func_addr;
  logic [3:0]  svc_ep_num;
  logic [1:0]  svc_dir;
  logic        svc_low_speed;
  logic [10:0] svc_max_pkt;
  logic        svc_toggle;
  logic        list_done;

  always #2.5 clk = ~clk;

  ed_walker u0 (
    .clk(clk), .rst(rst), .list_head(list_head), .start(start),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready), .rd_data(rd_data),
    .cur_ed(cur_ed), .svc_valid(svc_valid), .svc_ack(svc_ack),
    .svc_ed_addr(svc_ed_addr), .svc_td_addr(svc_td_addr),
    .svc_func_addr(svc_func_addr), .svc_ep_num(svc_ep_num), .svc_dir(svc_dir),
    .svc_low_speed(svc_low_speed), .svc_max_pkt(svc_max_pkt),
    .svc_toggle(svc_toggle), .list_done(list_done)
  );

  logic [31:0] mem [0:255];
  assign rd_data = mem[rd_addr[9:2]];

  int tests = 0, fails = 0, cycles = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int          ph = 0;          // 0 idle, 1 reading, 2 judging, 3 awaiting ack
  logic [31:0] got[$];
  logic [31:0] m_ed = 0;
  logic        e_rd_valid = 0, e_svc = 0, e_done = 0;
  logic [31:0] e_rd_addr = 0, e_cur = 0, e_svc_ed = 0, e_svc_td = 0, e_pay = 0;

  function automatic logic [31:0] pack_pay(input logic [31:0] c, input logic [31:0] h);
    return {6'd0, c[6:0], c[10:7], c[12:11], c[13], c[26:16], h[1]};
  endfunction

  task automatic step_on();
    logic [31:0] nx;
    nx = got[3] & 32'hFFFF_FFF0;
    if (nx == 0) begin
      e_done = 1; e_cur = 0; ph = 0;
    end else begin
      m_ed = nx; e_cur = nx; got.delete(); ph = 1;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      ph = 0; got.delete(); m_ed = 0; e_svc = 0; e_done = 0; e_cur = 0;
      e_svc_ed = 0; e_svc_td = 0; e_pay = 0;
    end else begin
      e_done = 0;
      case (ph)
        0: if (start) begin
          if ((list_head >> 4) == 0) begin e_done = 1; e_cur = 0; end
          else begin m_ed = list_head & 32'hFFFF_FFF0; e_cur = m_ed; got.delete(); ph = 1; end
        end
        1: if (rd_ready) begin
          got.push_back(mem[(m_ed + 32'(4 * got.size())) >> 2]);
          if (got.size() == 4) ph = 2;
        end
        2: begin
          if (!got[0][14] && !got[0][15] && !got[2][0] && (got[2][31:4] != got[1][31:4])) begin
            e_svc = 1; e_svc_ed = m_ed; e_svc_td = got[2] & 32'hFFFF_FFF0;
            e_pay = pack_pay(got[0], got[2]); ph = 3;
          end else step_on();
        end
        3: if (svc_ack) begin e_svc = 0; step_on(); end
        default: ph = 0;
      endcase
    end
    e_rd_valid = (ph == 1);
    e_rd_addr  = m_ed + 32'(4 * got.size());
  end

  // ---------------- stimulus for memory ready and acknowledge ----------------
  logic [7:0] lfsr = 8'h5A;
  bit  rdy_stall = 1;
  bit  stray_ack = 1;
  int  ack_dly = 2, ack_wait = 0;
  int  nreads = 0, nsvc = 0;

  always @(posedge clk) begin
    if (rd_valid && rd_ready) nreads++;
    if (svc_valid && svc_ack) nsvc++;
  end

  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    rd_ready = rdy_stall ? lfsr[0] : 1'b1;
    if (svc_valid) begin
      svc_ack = (ack_wait >= ack_dly);
      ack_wait++;
    end else begin
      svc_ack = stray_ack & lfsr[2] & lfsr[6];   // R8: stray acks must do nothing
      ack_wait = 0;
    end
  end

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    cycles++;
    if (!rst && !finished) begin
      check(rd_valid == e_rd_valid, "R2", "rd_valid", 32'(rd_valid), 32'(e_rd_valid));
      if (e_rd_valid) check(rd_addr == e_rd_addr, "R2", "rd_addr", rd_addr, e_rd_addr);
      check(cur_ed == e_cur, "R2", "cur_ed", cur_ed, e_cur);
      check(svc_valid == e_svc, "R7", "svc_valid", 32'(svc_valid), 32'(e_svc));
      if (e_svc) begin
        check(svc_ed_addr == e_svc_ed, "R7", "svc_ed_addr", svc_ed_addr, e_svc_ed);
        check(svc_td_addr == e_svc_td, "R7", "svc_td_addr", svc_td_addr, e_svc_td);
        check({6'd0, svc_func_addr, svc_ep_num, svc_dir, svc_low_speed, svc_max_pkt, svc_toggle}
              == e_pay, "R7", "fields", {6'd0, svc_func_addr, svc_ep_num, svc_dir,
              svc_low_speed, svc_max_pkt, svc_toggle}, e_pay);
      end
      check(list_done == e_done, "R9", "list_done", 32'(list_done), 32'(e_done));
    end
    if (cycles > 150000 && !finished) begin
      finished = 1;
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected list_done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- helpers ----------------
  task automatic put_ed(input logic [31:0] a, input logic [31:0] c, input logic [31:0] t,
                        input logic [31:0] h, input logic [31:0] n);
    mem[(a >> 2) + 0] = c;
    mem[(a >> 2) + 1] = t;
    mem[(a >> 2) + 2] = h;
    mem[(a >> 2) + 3] = n;
  endtask

  task automatic run_walk(input logic [31:0] head, input int exp_svc, input int exp_reads,
                          input bit extra_start, input string tag);
    int k = 0;
    bit seen = 0;
    nreads = 0; nsvc = 0;
    @(negedge clk); list_head = head; start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (list_done) seen = 1;
    while (!seen && cycles < 150000) begin
      k++;
      if (extra_start && (k == 3 || k == 20)) begin
        list_head = 32'h0; start = 1'b1;      // R11: must be ignored mid-walk
      end else start = 1'b0;
      @(negedge clk);
      if (list_done) seen = 1;
    end
    start = 1'b0;
    check(nsvc == exp_svc, tag, "service count", 32'(nsvc), 32'(exp_svc));
    check(nreads == exp_reads, tag, "read count", 32'(nreads), 32'(exp_reads));
    repeat (3) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    // six-descriptor chain, flag bits planted in pointer low nibbles
    put_ed(32'h100, 32'hF800_0000 | (32'd64 << 16) | (32'd1 << 13) | (32'd2 << 11) | (32'd5 << 7) | 32'd7,
           32'h0000_3000, 32'h0000_2002, 32'h0000_0149);                 // serviced, toggle 1
    put_ed(32'h140, (32'd1 << 14) | 32'h12, 32'h3100, 32'h2100, 32'h180); // R3 skip
    put_ed(32'h180, (32'd1 << 15) | 32'h22, 32'h3200, 32'h2200, 32'h1C0); // R4 isochronous
    put_ed(32'h1C0, 32'h33, 32'h3300, 32'h2301, 32'h200);                 // R5 halted
    put_ed(32'h200, 32'h44, 32'h2400, 32'h2406, 32'h240);                 // R6 empty, flags differ
    put_ed(32'h240, (32'd8 << 16) | (32'd1 << 11) | (32'd3 << 7) | 32'h7F,
           32'h5000, 32'h4500, 32'h0000_000C);                            // R9 next has flags only
    put_ed(32'h300, (32'd1 << 14), 32'h10, 32'h20, 32'h0);                 // lone skipped ED

    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(!rd_valid && !svc_valid && !list_done, "R1", "flags", 
          {29'd0, rd_valid, svc_valid, list_done}, 32'h0);
    check(cur_ed == 0 && svc_td_addr == 0 && svc_ed_addr == 0 && svc_max_pkt == 0,
          "R1", "pointers", cur_ed | svc_td_addr | svc_ed_addr, 32'h0);

    // R10: head with only flag bits set
    run_walk(32'h0000_0007, 0, 0, 0, "R10");
    // R3 R4 R5 R6 R7 R8 R9: full chain, stalling memory, delayed acks
    rdy_stall = 1; ack_dly = 2;
    run_walk(32'h0000_0105, 2, 24, 0, "R3_R4_R5_R6_R7");
    // R9: passed-over descriptor ends the list
    run_walk(32'h0000_0300, 0, 4, 0, "R9");
    // R11: repeat with no stalls, immediate acks and extra start pulses
    rdy_stall = 0; ack_dly = 0;
    run_walk(32'h0000_0100, 2, 24, 1, "R11");
    // R8: long acknowledge wait, stalling memory
    rdy_stall = 1; ack_dly = 7;
    run_walk(32'h0000_0100, 2, 24, 0, "R8");

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule